// File: doc/BRIEF.md
# Two-Stage Event-to-Host Interrupt Router

This block gathers up to 64 system event lines and turns them into 10 host interrupt lines. Each event is first made active-high by a per-event polarity bit. It is then captured either as a level or as a latched edge, according to a per-event type bit. A pending event that is also enabled is routed in two stages. A byte-wide map field picks one of 10 channels for the event, and a second byte-wide field picks one of 10 hosts for each channel. A host line rises only when that host has been enabled by an index write and the global enable bit is set.

Software reaches the block through a flat 32-bit register port with an 8-bit byte address. Writes take effect on the clock edge, and reads are combinational from the address. Event enables use bitmask set and clear words. Host enables use index writes, so each write enables or disables exactly one host. Host lines 0 and 1 are also reflected in a 32-bit status word, so a core that polls instead of taking interrupts can test two bits.

Top module: `irq_event_router`

## Requirements
- R1: After reset, the global enable, all host enables, all event enables, all channel and host map bytes and all event status read 0. Every polarity bit reads 1 and every type bit reads 0. All host outputs are low.
- R2: An event whose type bit is 1 (type words at 0x18 for events 0-31 and 0x1C for events 32-63) latches pending on its active edge, and stays pending until cleared. The active edge is rising when its polarity bit is 1 and falling when it is 0 (polarity words at 0x10 and 0x14).
- R3: An event whose type bit is 0 has a status that follows its polarity-corrected input, registered one clock later. A clear write does not hold it off.
- R4: Writing 1s to the status clear words (0x38 for events 0-31, 0x3C for events 32-63) clears latched edge status. Zero bits leave it unchanged, and an active edge in the same cycle wins over a clear. Reading either word returns the raw status.
- R5: Writing 1s to the enable set words (0x20, 0x24) sets enable bits, and writing 1s to the enable clear words (0x28, 0x2C) clears them. Zero bits have no effect. All four words read back the current enable mask.
- R6: Event n's channel sits in the byte at bits 8*(n%4)+7 down to 8*(n%4) of the word at 0x80+4*(n/4). Channel c's host sits in the same byte position of the word at 0xC0+4*(c/4). A map byte whose value exceeds 9 routes nowhere.
- R7: Writing a value below 10 to 0x04 enables that one host, and to 0x08 disables that one host. Values of 10 or more are ignored. Both words read back the 10-bit host enable mask.
- R8: Bit 0 of the word at 0x00 is the global enable. While it is 0 all host outputs stay low, but event status still latches.
- R9: Host output h is high exactly when the global enable is 1, host h is enabled, and some event is pending and enabled and maps to a channel that maps to h. The output follows the registered state with no further delay.
- R10: The status word (output, also readable at 0x0C) carries host 0 at bit 30 and host 1 at bit 31, with all other bits 0.
- R11: The raw status words (0x30, 0x34) return the pending bits. The enabled status words (0x40, 0x44) return pending AND enabled. Writes to these read-only words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 64 | System event lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, word aligned |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| host_irq | output | 10 | Host interrupt outputs |
| core_status | output | 32 | Polling word: host 0 at bit 30, host 1 at bit 31 |

## Verification
The bench builds the block with its default parameters: 64 events, 10 channels and 10 hosts. These put every event word, every channel map word and the partly used third host map word within reach. Random map bytes run from 0 to 11, so routes to the non-existent channels 10 and 11 and hosts 10 and 11 occur often. Random host index writes likewise include 10 and 11, which must be ignored. Directed cases cover the two-write host enable, an edge arriving in the same cycle as a clear, active-low level events and gating by the global bit.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Word indices (byte address / 4) of the register map
  localparam int W_GLB  = 0;   // 0x00 global enable
  localparam int W_HSET = 1;   // 0x04 host enable by index
  localparam int W_HCLR = 2;   // 0x08 host disable by index
  localparam int W_CORE = 3;   // 0x0C polling status word
  localparam int W_POL  = 4;   // 0x10.. polarity words
  localparam int W_TYP  = 6;   // 0x18.. type words
  localparam int W_ESET = 8;   // 0x20.. enable set
  localparam int W_ECLR = 10;  // 0x28.. enable clear
  localparam int W_RAW  = 12;  // 0x30.. raw status
  localparam int W_SCLR = 14;  // 0x38.. status clear (write 1)
  localparam int W_ENST = 16;  // 0x40.. enabled status
  localparam int W_CMAP = 32;  // 0x80.. channel map, byte per event
  localparam int W_HMAP = 48;  // 0xC0.. host map, byte per channel

  // True when a word index addresses register base+off
  function automatic logic hit(input logic [5:0] widx, input int base, input int off);
    return widx == 6'(base + off);
  endfunction

  // Polarity correction: 1 when the line is at its active level
  function automatic logic act_level(input logic line, input logic pol);
    return line ~^ pol;
  endfunction

  // A map byte selects target idx only when idx is a real target
  function automatic logic route_hit(input logic [7:0] field, input int idx, input int limit);
    return (idx < limit) && (field == 8'(idx));
  endfunction

endpackage

// File: rtl/irq_evt_capture.sv
module irq_evt_capture
  import irq_router_pkg::*;
#(
  parameter int NE = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_in,
  input  logic [NE-1:0] pol,
  input  logic [NE-1:0] typ,
  input  logic [NE-1:0] clr,
  output logic [NE-1:0] stat
);

  logic [NE-1:0] corr;   // active-high view of each line
  logic [NE-1:0] prev;   // corr one cycle ago
  logic [NE-1:0] rise;   // active edge seen this cycle

  for (genvar i = 0; i < NE; i++) begin : g_evt
    assign corr[i] = act_level(evt_in[i], pol[i]);
    assign rise[i] = corr[i] & ~prev[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev[i] <= 1'b0;
        stat[i] <= 1'b0;
      end else begin
        prev[i] <= corr[i];
        if (typ[i]) stat[i] <= rise[i] | (stat[i] & ~clr[i]);
        else        stat[i] <= corr[i];
      end
    end
  end

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat & typ & ~clr)) & ~stat) == '0)) else $error("edge status lost"); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(clr & typ & ~rise)) & stat) == '0)) else $error("clear ignored"); // R4

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(rise & typ)) & ~stat) == '0)) else $error("edge missed"); // R2

endmodule

// File: rtl/irq_route_stage.sv
module irq_route_stage
  import irq_router_pkg::*;
#(
  parameter int NE = 64,
  parameter int NC = 10,
  parameter int NH = 10
) (
  input  logic [NE-1:0]       pend_en,
  input  logic [NE-1:0][7:0]  cmap,
  input  logic [NC-1:0][7:0]  hmap,
  input  logic [NH-1:0]       host_en,
  input  logic                glb_en,
  output logic [NH-1:0]       host_irq
);

  logic [NC-1:0] chan_act;   // stage one: channel has a live event
  logic [NH-1:0] host_act;   // stage two: host has a live channel

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      chan_act[c] = 1'b0;
      for (int e = 0; e < NE; e++)
        chan_act[c] = chan_act[c] | (pend_en[e] & route_hit(cmap[e], c, NC));
    end
  end

  always_comb begin
    for (int h = 0; h < NH; h++) begin
      host_act[h] = 1'b0;
      for (int c = 0; c < NC; c++)
        host_act[h] = host_act[h] | (chan_act[c] & route_hit(hmap[c], h, NH));
    end
  end

  assign host_irq = host_act & host_en & {NH{glb_en}};

endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
  import irq_router_pkg::*;
#(
  parameter int NE = 64,
  parameter int NC = 10,
  parameter int NH = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_in,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [NH-1:0] host_irq,
  output logic [31:0]   core_status
);

  localparam int EW = NE / 32;          // event words
  localparam int HW = $clog2(NH);       // host index width

  logic [5:0]          widx;
  logic                a_ok;
  logic                glb_en;
  logic [NH-1:0]       host_en;
  logic [NE-1:0]       pol, typ, en, stat, clr;
  logic [NE-1:0][7:0]  cmap;
  logic [NC-1:0][7:0]  hmap;
  logic                wsel_hset, wsel_hclr, idx_ok;

  assign widx      = reg_addr[7:2];
  assign a_ok      = (reg_addr[1:0] == 2'b00);
  assign wsel_hset = reg_wr && a_ok && hit(widx, W_HSET, 0);
  assign wsel_hclr = reg_wr && a_ok && hit(widx, W_HCLR, 0);
  assign idx_ok    = reg_wdata < 32'(NH);

  // Status clear strobes, one word per event word
  always_comb begin
    clr = '0;
    for (int w = 0; w < EW; w++)
      if (reg_wr && a_ok && hit(widx, W_SCLR, w)) clr[w*32 +: 32] = reg_wdata;
  end

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      host_en <= '0;
      pol     <= '1;
      typ     <= '0;
      en      <= '0;
      cmap    <= '0;
      hmap    <= '0;
    end else if (reg_wr && a_ok) begin
      if (hit(widx, W_GLB, 0)) glb_en <= reg_wdata[0];
      if (wsel_hset && idx_ok) host_en[reg_wdata[HW-1:0]] <= 1'b1;
      if (wsel_hclr && idx_ok) host_en[reg_wdata[HW-1:0]] <= 1'b0;
      for (int w = 0; w < EW; w++) begin
        if (hit(widx, W_POL, w))  pol[w*32 +: 32] <= reg_wdata;
        if (hit(widx, W_TYP, w))  typ[w*32 +: 32] <= reg_wdata;
        if (hit(widx, W_ESET, w)) en[w*32 +: 32]  <= en[w*32 +: 32] | reg_wdata;
        if (hit(widx, W_ECLR, w)) en[w*32 +: 32]  <= en[w*32 +: 32] & ~reg_wdata;
      end
      for (int e = 0; e < NE; e++)
        if (hit(widx, W_CMAP, e / 4)) cmap[e] <= reg_wdata[8*(e%4) +: 8];
      for (int c = 0; c < NC; c++)
        if (hit(widx, W_HMAP, c / 4)) hmap[c] <= reg_wdata[8*(c%4) +: 8];
    end
  end

  irq_evt_capture #(.NE(NE)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_in),
    .pol    (pol),
    .typ    (typ),
    .clr    (clr),
    .stat   (stat)
  );

  irq_route_stage #(.NE(NE), .NC(NC), .NH(NH)) u_route (
    .pend_en  (stat & en),
    .cmap     (cmap),
    .hmap     (hmap),
    .host_en  (host_en),
    .glb_en   (glb_en),
    .host_irq (host_irq)
  );

  assign core_status = {host_irq[1], host_irq[0], 30'b0};

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (a_ok) begin
      if (hit(widx, W_GLB, 0))  reg_rdata = {31'b0, glb_en};
      if (hit(widx, W_HSET, 0) || hit(widx, W_HCLR, 0)) reg_rdata = 32'(host_en);
      if (hit(widx, W_CORE, 0)) reg_rdata = core_status;
      for (int w = 0; w < EW; w++) begin
        if (hit(widx, W_POL, w)) reg_rdata = pol[w*32 +: 32];
        if (hit(widx, W_TYP, w)) reg_rdata = typ[w*32 +: 32];
        if (hit(widx, W_ESET, w) || hit(widx, W_ECLR, w)) reg_rdata = en[w*32 +: 32];
        if (hit(widx, W_RAW, w) || hit(widx, W_SCLR, w))  reg_rdata = stat[w*32 +: 32];
        if (hit(widx, W_ENST, w)) reg_rdata = stat[w*32 +: 32] & en[w*32 +: 32];
      end
      for (int e = 0; e < NE; e++)
        if (hit(widx, W_CMAP, e / 4)) reg_rdata[8*(e%4) +: 8] = cmap[e];
      for (int c = 0; c < NC; c++)
        if (hit(widx, W_HMAP, c / 4)) reg_rdata[8*(c%4) +: 8] = hmap[c];
    end
  end

  AST_GLB_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (host_irq == '0)) else $error("host out while globally off"); // R8

  AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq & ~host_en) == '0) else $error("disabled host asserted"); // R9

  AST_IDX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel_hset && idx_ok) |=> host_en[$past(reg_wdata[HW-1:0])]) else $error("index set lost"); // R7

  AST_IDX_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel_hset || wsel_hclr) |=> ($countones(host_en ^ $past(host_en)) <= 1)) else $error("index write touched two hosts"); // R7

  AST_HOST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && a_ok) |=> $stable(host_en)) else $error("host enable changed without write"); // R7

endmodule

// File: tb/test_irq_event_router.sv
module test_irq_event_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire  [9:0]  irq;
  wire  [31:0] core;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_event_router i_irq_event_router (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .host_irq(irq), .core_status(core)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model of the programmer-visible state
  logic        m_glb;
  logic [9:0]  m_hen;
  logic [63:0] m_pol, m_typ, m_en, m_stat, m_prev;
  logic [7:0]  m_cmap [64];
  logic [7:0]  m_hmap [10];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_irq();
    logic [9:0] r = '0;
    for (int h = 0; h < 10; h++)
      for (int e = 0; e < 64; e++)
        if (m_stat[e] && m_en[e] && m_cmap[e] < 8'd10)
          if (m_hmap[m_cmap[e][3:0]] == 8'(h)) r[h] = 1'b1;
    return r & m_hen & {10{m_glb}};
  endfunction

  function automatic logic [31:0] exp_core();
    logic [9:0] r = exp_irq();
    return {r[1], r[0], 30'b0};
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = '0;
    case (a)
      8'h00: r = {31'b0, m_glb};
      8'h04, 8'h08: r = {22'b0, m_hen};
      8'h0C: r = exp_core();
      8'h10: r = m_pol[31:0];   8'h14: r = m_pol[63:32];
      8'h18: r = m_typ[31:0];   8'h1C: r = m_typ[63:32];
      8'h20, 8'h28: r = m_en[31:0];
      8'h24, 8'h2C: r = m_en[63:32];
      8'h30, 8'h38: r = m_stat[31:0];
      8'h34, 8'h3C: r = m_stat[63:32];
      8'h40: r = m_stat[31:0] & m_en[31:0];
      8'h44: r = m_stat[63:32] & m_en[63:32];
      default: begin
        if (a >= 8'h80 && a <= 8'hBC) begin
          for (int b = 0; b < 4; b++) r[8*b +: 8] = m_cmap[(a - 8'h80) + 8'(b)];
        end else if (a >= 8'hC0 && a <= 8'hC8) begin
          for (int b = 0; b < 4; b++)
            if ((a - 8'hC0) + 8'(b) < 8'd10) r[8*b +: 8] = m_hmap[(a - 8'hC0) + 8'(b)];
        end
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h00) return "R8 global read";
    if (a == 8'h04 || a == 8'h08) return "R7 host mask read";
    if (a == 8'h0C) return "R10 status word read";
    if (a < 8'h20) return "R2 polarity/type read";
    if (a < 8'h30) return "R5 enable read";
    if (a == 8'h38 || a == 8'h3C) return "R4 clear word read";
    if (a < 8'h48) return "R11 status read";
    return "R6 map read";
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: m_glb = d[0];
      8'h04: if (d < 32'd10) m_hen[d[3:0]] = 1'b1;
      8'h08: if (d < 32'd10) m_hen[d[3:0]] = 1'b0;
      8'h10: m_pol[31:0] = d;   8'h14: m_pol[63:32] = d;
      8'h18: m_typ[31:0] = d;   8'h1C: m_typ[63:32] = d;
      8'h20: m_en[31:0]  = m_en[31:0] | d;
      8'h24: m_en[63:32] = m_en[63:32] | d;
      8'h28: m_en[31:0]  = m_en[31:0] & ~d;
      8'h2C: m_en[63:32] = m_en[63:32] & ~d;
      default: begin
        if (a >= 8'h80 && a <= 8'hBC) begin
          for (int b = 0; b < 4; b++) m_cmap[(a - 8'h80) + 8'(b)] = d[8*b +: 8];
        end else if (a >= 8'hC0 && a <= 8'hC8) begin
          for (int b = 0; b < 4; b++)
            if ((a - 8'hC0) + 8'(b) < 8'd10) m_hmap[(a - 8'hC0) + 8'(b)] = d[8*b +: 8];
        end
      end
    endcase
  endtask

  // One clock: model the edge, then compare outputs just after it
  task automatic tick();
    logic [63:0] corr, rise, clrm, nstat;
    corr = ~(evt ^ m_pol);
    rise = corr & ~m_prev;
    clrm = '0;
    if (wr && addr == 8'h38) clrm[31:0] = wdata;
    if (wr && addr == 8'h3C) clrm[63:32] = wdata;
    for (int i = 0; i < 64; i++)
      nstat[i] = m_typ[i] ? (rise[i] | (m_stat[i] & ~clrm[i])) : corr[i];
    if (wr) model_write(addr, wdata);
    @(posedge clk);
    #1;
    m_stat = nstat;
    m_prev = corr;
    wr = 1'b0;
    chk("R9 host outputs", 64'(irq), 64'(exp_irq()));
    chk("R10 status word", 64'(core), 64'(exp_core()));
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
  endtask

  task automatic rd_chk(input logic [7:0] a);
    addr = a;
    #1;
    chk(tag_of(a), 64'(rdata), 64'(exp_read(a)));
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] v);
    addr = a;
    #1;
    chk(tag, 64'(rdata), 64'(v));
  endtask

  function automatic logic [7:0] pick_addr(input int k);
    if (k < 18) return 8'(4 * k);
    if (k < 34) return 8'h80 + 8'(4 * (k - 18));
    return 8'hC0 + 8'(4 * (k - 34));
  endfunction

  function automatic logic [31:0] rnd_map();
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = 8'($urandom_range(0, 11));
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_glb = 0; m_hen = '0; m_pol = '1; m_typ = '0; m_en = '0; m_stat = '0; m_prev = '0;
    for (int i = 0; i < 64; i++) m_cmap[i] = '0;
    for (int i = 0; i < 10; i++) m_hmap[i] = '0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1 host outputs at reset", 64'(irq), 64'h0);
    rd_lit("R1 polarity word 0 reset", 8'h10, 32'hFFFF_FFFF);
    rd_lit("R1 polarity word 1 reset", 8'h14, 32'hFFFF_FFFF);
    rd_lit("R1 type reset", 8'h18, 32'h0);
    rd_lit("R1 enable reset", 8'h24, 32'h0);
    rd_lit("R1 global reset", 8'h00, 32'h0);
    rd_lit("R1 host mask reset", 8'h04, 32'h0);
    rd_lit("R1 channel map reset", 8'hBC, 32'h0);
    rd_lit("R1 host map reset", 8'hC8, 32'h0);

    // R7: one host per index write, out-of-range ignored
    wreg(8'h04, 32'd0);  rd_lit("R7 enable host 0", 8'h04, 32'h1);
    wreg(8'h04, 32'd11); rd_lit("R7 index 11 ignored", 8'h04, 32'h1);
    wreg(8'h04, 32'd10); rd_lit("R7 index 10 ignored", 8'h04, 32'h1);
    wreg(8'h04, 32'd1);  rd_lit("R7 second write adds host 1", 8'h04, 32'h3);
    wreg(8'h08, 32'd0);  rd_lit("R7 clear host 0 only", 8'h08, 32'h2);
    wreg(8'h08, 32'd1);

    // R2/R6/R9: event 7 edge -> channel 1 -> host 3
    wreg(8'h18, 32'h80);
    wreg(8'h20, 32'h80);
    rd_lit("R5 set reads mask", 8'h28, 32'h80);
    wreg(8'h84, 32'h0100_0000);
    wreg(8'hC0, 32'h0000_0300);
    wreg(8'h04, 32'd3);
    wreg(8'h00, 32'd1);
    evt[7] = 1'b1; tick();
    chk("R9 event 7 reaches host 3", 64'(irq), 64'h008);
    evt[7] = 1'b0; tick();
    chk("R2 edge status held", 64'(irq), 64'h008);
    wreg(8'h38, 32'h0);
    chk("R4 zero clear no effect", 64'(irq), 64'h008);
    wreg(8'h38, 32'h80);
    chk("R4 one clears", 64'(irq), 64'h000);
    // R4: edge in the same cycle as a clear wins
    evt[7] = 1'b1; addr = 8'h38; wdata = 32'h80; wr = 1'b1; tick();
    chk("R4 edge beats clear", 64'(irq), 64'h008);
    evt[7] = 1'b0; wreg(8'h38, 32'h80);
    wreg(8'h20, 32'h0);
    rd_lit("R5 zero set no effect", 8'h20, 32'h80);
    wreg(8'h28, 32'h0);
    rd_lit("R5 zero clear no effect", 8'h2C, 32'h0);
    rd_lit("R5 zero clear no effect lo", 8'h28, 32'h80);

    // R6: channel byte above 9 routes nowhere
    wreg(8'h84, 32'h0A00_0000);
    evt[7] = 1'b1; tick(); evt[7] = 1'b0; tick();
    chk("R6 channel 10 routes nowhere", 64'(irq), 64'h000);
    rd_lit("R11 raw status latched", 8'h30, 32'h80);
    rd_lit("R11 enabled status", 8'h40, 32'h80);
    wreg(8'h30, 32'h0);
    rd_lit("R11 raw word ignores writes", 8'h30, 32'h80);
    wreg(8'h38, 32'h80);

    // R8: global enable gates but status still latches
    wreg(8'h84, 32'h0100_0000);
    wreg(8'h00, 32'd0);
    evt[7] = 1'b1; tick(); evt[7] = 1'b0; tick();
    chk("R8 gated while global off", 64'(irq), 64'h000);
    rd_lit("R8 status latched while off", 8'h30, 32'h80);
    wreg(8'h00, 32'd1);
    chk("R8 output after global on", 64'(irq), 64'h008);
    wreg(8'h38, 32'h80);

    // R3: level type, active low
    wreg(8'h18, 32'h0);
    wreg(8'h10, 32'hFFFF_FF7F);
    evt[7] = 1'b0; tick();
    chk("R3 active-low level pending", 64'(irq), 64'h008);
    wreg(8'h38, 32'h80);
    chk("R3 clear cannot hold off level", 64'(irq), 64'h008);
    evt[7] = 1'b1; tick();
    chk("R3 level released", 64'(irq), 64'h000);
    wreg(8'h10, 32'hFFFF_FFFF);

    // R10: hosts 0 and 1 in the status word
    wreg(8'h84, 32'h0);
    wreg(8'h04, 32'd0);
    evt[7] = 1'b1; tick();
    chk("R10 host 0 at bit 30", 64'(core), 64'h4000_0000);
    wreg(8'hC0, 32'h1);
    wreg(8'h04, 32'd1);
    chk("R10 host 1 at bit 31", 64'(core), 64'h8000_0000);
    evt = '0; tick();

    // Constrained random phase
    for (int it = 0; it < 3000; it++) begin
      evt = evt ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      if ($urandom_range(0, 2) == 0) begin
        case ($urandom_range(0, 11))
          0:  wreg(8'h00, 32'($urandom_range(0, 4) != 0));
          1:  wreg(8'h04, 32'($urandom_range(0, 11)));
          2:  wreg(8'h08, 32'($urandom_range(0, 11)));
          3:  wreg(8'h10 + 8'(4 * $urandom_range(0, 1)), ~($urandom & $urandom & $urandom));
          4:  wreg(8'h18 + 8'(4 * $urandom_range(0, 1)), $urandom);
          5:  wreg(8'h20 + 8'(4 * $urandom_range(0, 1)), $urandom);
          6:  wreg(8'h28 + 8'(4 * $urandom_range(0, 1)), $urandom & $urandom & $urandom);
          7:  wreg(8'h38 + 8'(4 * $urandom_range(0, 1)), $urandom);
          8:  wreg(8'h80 + 8'(4 * $urandom_range(0, 15)), rnd_map());
          9:  wreg(8'hC0 + 8'(4 * $urandom_range(0, 2)), rnd_map());
          10: wreg(8'h40 + 8'(4 * $urandom_range(0, 1)), $urandom);
          default: wreg(8'h0C, $urandom);
        endcase
      end else begin
        tick();
      end
      rd_chk(pick_addr(int'($urandom_range(0, 36))));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule